// File: doc/BRIEF.md
# Gray-Level Framebuffer Pixel Expander

The block reads a packed framebuffer in which every byte carries two 4-bit gray levels and turns the visible part into a stream of colour pixels for a display pipeline. It shows ROWS framebuffer rows of ROW_BYTES bytes each. Every pixel is repeated MAG times along the line, and every line is repeated MAG times down the frame. With the defaults (64 rows, 64 bytes, factor 4) one frame is 512 by 256 output pixels. Each gray level is converted on the fly into one of four colour encodings, and the result is placed right-justified on a 32-bit bus.

A frame is drawn only on demand. A one-cycle pulse on `redraw_req` sets a pending flag. The expander starts a frame when it is idle and the flag is set, and it clears the flag when the last pixel of the frame is taken. The framebuffer is read through a synchronous read port whose data comes back one cycle after the request. The output is a valid/ready stream carrying a start-of-frame marker and an end-of-line marker. A small byte FIFO between the read port and the pixel side lets reads run ahead, so backpressure never loses or repeats a byte.

Top module: `gfx_gray_expander`

## Requirements
- R1: After reset, `pix_valid` and `mem_rd` stay low until a redraw is requested.
- R2: One pulse on `redraw_req` produces exactly one frame. A further pulse that arrives while that frame is still being drawn is absorbed and does not add a frame. After the last pixel is accepted, no pixel appears until the next request.
- R3: Output line L shows framebuffer row L/MAG. Its k-th read is at address (L/MAG)*ROW_BYTES + k, for k from 0 to ROW_BYTES-1.
- R4: Of each byte, bits 7:4 give the left pixel and bits 3:0 give the right pixel.
- R5: A frame has ROWS*MAG lines of 2*ROW_BYTES*MAG pixels, and each pixel repeats MAG times in a row.
- R6: With `fmt_sel`=2 (24-bit) or `fmt_sel`=3 (32-bit), with c={g,g}, the pixel is {8'h00,c,c,c}.
- R7: With `fmt_sel`=0 (15-bit), the 5-bit intensity is n=2g+(g>>3) and the pixel is {17'b0,n,n,n}.
- R8: With `fmt_sel`=1 (16-bit), the pixel uses the same n and is {16'b0,n,n,n[4],n}. The green field is six bits wide, with its low bit copied from the intensity MSB.
- R9: `pix_sof` is high only on the first pixel of a frame. `pix_eol` is high only on the last pixel of each output line.
- R10: While `pix_valid` is high and `pix_ready` is low, the data and both markers hold, and no pixel is dropped or duplicated.
- R11: The format is sampled when a frame starts. Changing `fmt_sel` during the frame has no effect until the next frame.
- R12: A frame issues exactly ROWS*MAG*ROW_BYTES reads. The FIFO never receives a byte when it has no room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redraw_req | input | 1 | One-cycle pulse that requests a frame |
| fmt_sel | input | 2 | Colour encoding: 0=15-bit, 1=16-bit, 2=24-bit, 3=32-bit |
| mem_rd | output | 1 | Framebuffer read strobe |
| mem_addr | output | ADDR_W | Framebuffer byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Sink accepts the pixel |
| pix_data | output | 32 | Right-justified colour pixel |
| pix_sof | output | 1 | First pixel of the frame |
| pix_eol | output | 1 | Last pixel of a line |

## Verification
The bound checker watches, on every cycle, that the data and markers hold under backpressure and that the start-of-frame marker never appears on two accepted pixels in a row. It also checks that a frame only ends on an accepted end-of-line pixel, that the latched format stays fixed through a frame, and that the colour fields of each format are replicated consistently. FIFO occupancy and room on each push are checked every cycle as well. What only the scenarios can show is the full frame content: the read order, the nibble order, the magnification in both axes and the exact colour value for each gray level. The same goes for merging a second request and ignoring a format change in mid-frame. The bench compares every frame pixel by pixel against its own model for all four formats, under steady and random backpressure.

// File: rtl/gfx_expand_pkg.sv
package gfx_expand_pkg;

  localparam int GRAY_W = 4;
  localparam int BYTE_W = 8;
  localparam int PIX_W  = 32;

  typedef enum logic [1:0] {
    FMT_RGB15 = 2'd0,
    FMT_RGB16 = 2'd1,
    FMT_RGB24 = 2'd2,
    FMT_RGB32 = 2'd3
  } pix_fmt_e;

endpackage

// File: rtl/gfx_color_conv.sv
module gfx_color_conv
  import gfx_expand_pkg::*;
(
  input  pix_fmt_e           fmt,
  input  logic [GRAY_W-1:0]  gray,
  output logic [PIX_W-1:0]   pixel
);

  logic [4:0] n5;
  logic [7:0] c8;

  // 2g + (g>>3) equals g shifted left once with its MSB appended
  assign n5 = {gray, gray[GRAY_W-1]};
  assign c8 = {gray, gray};

  always_comb begin
    unique case (fmt)
      FMT_RGB15: pixel = {17'b0, n5, n5, n5};
      FMT_RGB16: pixel = {16'b0, n5, n5, n5[4], n5};
      default:   pixel = {8'b0, c8, c8, c8};
    endcase
  end

endmodule

// File: rtl/gfx_byte_fifo.sv
module gfx_byte_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty
);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? bump(wp_q) : wp_q;
    rp_d  = pop  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (push || pop) begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wen;
    assign wen = push && (wp_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[i] <= '0;
      else if (wen) slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[rp_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/gfx_fetch_seq.sv
module gfx_fetch_seq #(
  parameter int ROWS      = 64,
  parameter int ROW_BYTES = 64,
  parameter int MAG       = 4,
  parameter int AW        = 12,
  localparam int CW       = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1,
  localparam int MW       = (MAG > 1) ? $clog2(MAG) : 1,
  localparam int RW       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          issue,
  output logic [AW-1:0] addr,
  output logic          done
);

  logic [CW-1:0] col_q, col_d;
  logic [MW-1:0] rep_q, rep_d;
  logic [RW-1:0] row_q, row_d;
  logic [AW-1:0] base_q, base_d;
  logic          done_q, done_d;
  logic          col_last, rep_last, row_last;

  assign col_last = (col_q == CW'(ROW_BYTES - 1));
  assign rep_last = (rep_q == MW'(MAG - 1));
  assign row_last = (row_q == RW'(ROWS - 1));

  always_comb begin
    col_d  = col_q;
    rep_d  = rep_q;
    row_d  = row_q;
    base_d = base_q;
    done_d = done_q;
    if (start) begin
      col_d  = '0;
      rep_d  = '0;
      row_d  = '0;
      base_d = '0;
      done_d = 1'b0;
    end else if (issue) begin
      if (col_last) begin
        col_d = '0;
        if (rep_last) begin
          rep_d  = '0;
          row_d  = row_q + 1'b1;
          base_d = base_q + AW'(ROW_BYTES);
          if (row_last) done_d = 1'b1;
        end else begin
          rep_d = rep_q + 1'b1;
        end
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      rep_q  <= '0;
      row_q  <= '0;
      base_q <= '0;
      done_q <= 1'b1;
    end else if (start || issue) begin
      col_q  <= col_d;
      rep_q  <= rep_d;
      row_q  <= row_d;
      base_q <= base_d;
      done_q <= done_d;
    end
  end

  assign addr = base_q + AW'(col_q);
  assign done = done_q;

endmodule

// File: rtl/gfx_pixel_seq.sv
module gfx_pixel_seq #(
  parameter int ROWS      = 64,
  parameter int ROW_BYTES = 64,
  parameter int MAG       = 4,
  localparam int CW       = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1,
  localparam int MW       = (MAG > 1) ? $clog2(MAG) : 1,
  localparam int RW       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic adv,
  output logic nib_lo,
  output logic byte_end,
  output logic sof,
  output logic eol,
  output logic frame_end
);

  logic [MW-1:0] hrep_q, hrep_d;
  logic          half_q, half_d;
  logic [CW-1:0] col_q, col_d;
  logic [MW-1:0] vrep_q, vrep_d;
  logic [RW-1:0] row_q, row_d;
  logic          hrep_last, col_last, vrep_last, row_last;

  assign hrep_last = (hrep_q == MW'(MAG - 1));
  assign col_last  = (col_q == CW'(ROW_BYTES - 1));
  assign vrep_last = (vrep_q == MW'(MAG - 1));
  assign row_last  = (row_q == RW'(ROWS - 1));

  assign byte_end  = hrep_last && half_q;
  assign eol       = byte_end && col_last;
  assign frame_end = eol && vrep_last && row_last;
  assign sof       = (hrep_q == '0) && !half_q && (col_q == '0) &&
                     (vrep_q == '0) && (row_q == '0);
  assign nib_lo    = half_q;

  always_comb begin
    hrep_d = hrep_q;
    half_d = half_q;
    col_d  = col_q;
    vrep_d = vrep_q;
    row_d  = row_q;
    if (start || (adv && frame_end)) begin
      hrep_d = '0;
      half_d = 1'b0;
      col_d  = '0;
      vrep_d = '0;
      row_d  = '0;
    end else if (adv) begin
      if (!hrep_last) begin
        hrep_d = hrep_q + 1'b1;
      end else begin
        hrep_d = '0;
        half_d = !half_q;
        if (half_q) begin
          if (!col_last) begin
            col_d = col_q + 1'b1;
          end else begin
            col_d = '0;
            if (!vrep_last) begin
              vrep_d = vrep_q + 1'b1;
            end else begin
              vrep_d = '0;
              row_d  = row_q + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrep_q <= '0;
      half_q <= 1'b0;
      col_q  <= '0;
      vrep_q <= '0;
      row_q  <= '0;
    end else if (start || adv) begin
      hrep_q <= hrep_d;
      half_q <= half_d;
      col_q  <= col_d;
      vrep_q <= vrep_d;
      row_q  <= row_d;
    end
  end

endmodule

// File: rtl/gfx_gray_expander.sv
module gfx_gray_expander
  import gfx_expand_pkg::*;
#(
  parameter int ROWS      = 64,
  parameter int ROW_BYTES = 64,
  parameter int MAG       = 4,
  parameter int ADDR_W    = $clog2(ROWS * ROW_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redraw_req,
  input  logic [1:0]        fmt_sel,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [31:0]       pix_data,
  output logic              pix_sof,
  output logic              pix_eol
);

  localparam int FIFO_DEPTH = 2;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

  logic       active_q, active_d;
  logic       redraw_q, redraw_d;
  pix_fmt_e   fmt_q, fmt_d;
  logic       inflight_q;

  logic              start, issue, fire, pop, frame_done, credit_ok;
  logic              fetch_done;
  logic              fifo_push, fifo_empty;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [BYTE_W-1:0] head;
  logic              nib_lo, byte_end, sof_raw, eol_raw, frame_end;
  logic [GRAY_W-1:0] gray;

  // Frame control
  assign start      = !active_q && redraw_q;
  assign credit_ok  = (int'(fifo_cnt) + int'(inflight_q)) < FIFO_DEPTH;
  assign issue      = active_q && !fetch_done && credit_ok;
  assign fire       = pix_valid && pix_ready;
  assign pop        = fire && byte_end;
  assign frame_done = fire && frame_end;
  assign fifo_push  = inflight_q;

  always_comb begin
    active_d = active_q;
    if (start)           active_d = 1'b1;
    else if (frame_done) active_d = 1'b0;
    redraw_d = redraw_req || (redraw_q && !frame_done);
    fmt_d    = start ? pix_fmt_e'(fmt_sel) : fmt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      redraw_q   <= 1'b0;
      fmt_q      <= FMT_RGB15;
      inflight_q <= 1'b0;
    end else begin
      active_q   <= active_d;
      redraw_q   <= redraw_d;
      inflight_q <= issue;
      if (start) fmt_q <= fmt_d;
    end
  end

  gfx_fetch_seq #(
    .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .MAG(MAG), .AW(ADDR_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .issue(issue),
    .addr(mem_addr), .done(fetch_done)
  );

  gfx_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(mem_rdata),
    .pop(pop), .rdata(head), .count(fifo_cnt), .empty(fifo_empty)
  );

  gfx_pixel_seq #(
    .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .MAG(MAG)
  ) u_pix (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(fire),
    .nib_lo(nib_lo), .byte_end(byte_end), .sof(sof_raw), .eol(eol_raw),
    .frame_end(frame_end)
  );

  assign gray = nib_lo ? head[GRAY_W-1:0] : head[BYTE_W-1:GRAY_W];

  gfx_color_conv u_conv (.fmt(fmt_q), .gray(gray), .pixel(pix_data));

  assign mem_rd    = issue;
  assign pix_valid = active_q && !fifo_empty;
  assign pix_sof   = pix_valid && sof_raw;
  assign pix_eol   = pix_valid && eol_raw;

endmodule

// File: rtl/gfx_gray_expander_chk.sv
module gfx_gray_expander_chk #(
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic [31:0]   pix_data,
  input logic          pix_sof,
  input logic          pix_eol,
  input logic [1:0]    fmt_q,
  input logic          active_q,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_push
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data) &&
                                $stable(pix_sof) && $stable(pix_eol));

  p_sof_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && pix_sof |=> !pix_sof);

  p_end_on_eol_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(pix_valid && pix_ready && pix_eol));

  p_fmt_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && $past(active_q) |-> $stable(fmt_q));

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= DEPTH);

  p_push_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> int'(fifo_cnt) < DEPTH);

  p_gray24_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && fmt_q[1] |-> pix_data[31:24] == 8'h00 &&
      pix_data[23:16] == pix_data[15:8] && pix_data[15:8] == pix_data[7:0] &&
      pix_data[7:4] == pix_data[3:0]);

  p_gray15_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && fmt_q == 2'd0 |-> pix_data[31:15] == '0 &&
      pix_data[14:10] == pix_data[9:5] && pix_data[9:5] == pix_data[4:0]);

endmodule

bind gfx_gray_expander gfx_gray_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_data(pix_data), .pix_sof(pix_sof), .pix_eol(pix_eol),
  .fmt_q(fmt_q), .active_q(active_q), .fifo_cnt(fifo_cnt),
  .fifo_push(fifo_push)
);

// File: tb/gfx_gray_expander_tb.sv
`timescale 1ns/1ps
module gfx_gray_expander_tb;

  localparam int ROWS  = 3;
  localparam int RB    = 3;
  localparam int MAG   = 2;
  localparam int AW    = $clog2(ROWS * RB);
  localparam int NRD   = ROWS * MAG * RB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          redraw_req;
  logic [1:0]    fmt_sel;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;
  logic          pix_valid;
  logic          pix_ready = 1'b1;
  logic [31:0]   pix_data;
  logic          pix_sof, pix_eol;

  always #2.5 clk = ~clk;

  gfx_gray_expander #(.ROWS(ROWS), .ROW_BYTES(RB), .MAG(MAG), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .redraw_req(redraw_req), .fmt_sel(fmt_sel),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_eol(pix_eol)
  );

  logic [7:0] fb [ROWS*RB];
  always @(posedge clk) if (mem_rd) mem_rdata <= fb[mem_addr];

  typedef struct packed { logic [31:0] d; logic sof; logic eol; } exp_t;
  exp_t  q[$];
  int    checks = 0;
  int    fails  = 0;
  int    rd_idx = 0;
  bit    rand_ready = 0;
  logic [15:0] lfsr = 16'hACE1;
  string fmt_req = "R6";
  bit    hold_pend = 0;
  exp_t  hold_val;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_col(input int fmt, input int g);
    int n, c;
    n = 2 * g + g / 8;
    c = g * 17;
    case (fmt)
      0:       return n + n * 32 + n * 1024;
      1:       return n + n * 64 + (n / 16) * 32 + n * 2048;
      default: return c * 65536 + c * 256 + c;
    endcase
  endfunction

  // Driver side of the scoreboard: full expected frame
  task automatic push_frame(input int fmt);
    for (int line = 0; line < ROWS * MAG; line++) begin
      for (int col = 0; col < RB; col++) begin
        for (int half = 0; half < 2; half++) begin
          for (int h = 0; h < MAG; h++) begin
            exp_t e;
            logic [7:0] b;
            b     = fb[(line / MAG) * RB + col];
            e.d   = 32'(exp_col(fmt, half ? int'(b[3:0]) : int'(b[7:4])));
            e.sof = (line == 0 && col == 0 && half == 0 && h == 0);
            e.eol = (col == RB - 1 && half == 1 && h == MAG - 1);
            q.push_back(e);
          end
        end
      end
    end
  endtask

  // Monitor: ready generation, hold check, pixel and read compare
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_ready = rand_ready ? lfsr[0] : 1'b1;
      if (hold_pend) begin
        check(pix_valid && pix_data == hold_val.d && pix_sof == hold_val.sof &&
              pix_eol == hold_val.eol, "R10", "hold under stall",
              {pix_valid, pix_data, pix_sof, pix_eol},
              {1'b1, hold_val.d, hold_val.sof, hold_val.eol});
      end
      hold_pend = pix_valid && !pix_ready;
      hold_val  = '{d: pix_data, sof: pix_sof, eol: pix_eol};
      if (pix_valid && pix_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected pixel", pix_data, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          // R4 R5 nibble order and magnification live in the expected sequence
          check(pix_data == e.d, fmt_req, "pixel value (R4/R5)", pix_data, e.d);
          check(pix_sof == e.sof && pix_eol == e.eol, "R9", "markers",
                {pix_sof, pix_eol}, {e.sof, e.eol});
        end
      end
      if (mem_rd) begin
        int exp_a;
        exp_a = ((rd_idx / RB) / MAG) * RB + (rd_idx % RB);
        check(int'(mem_addr) == exp_a, "R3", "read address", mem_addr, exp_a);
        rd_idx++;
      end
    end
  end

  task automatic run_frame(input int fmt, input bit extra_req, input bit fmt_flip);
    fmt_sel = 2'(fmt);
    fmt_req = (fmt == 0) ? "R7" : (fmt == 1) ? "R8" : "R6";
    push_frame(fmt);
    rd_idx = 0;
    @(negedge clk) redraw_req = 1'b1;
    @(negedge clk) redraw_req = 1'b0;
    if (extra_req || fmt_flip) begin
      repeat (20) @(negedge clk);
      if (extra_req) begin
        redraw_req = 1'b1;
        @(negedge clk) redraw_req = 1'b0;
      end
      // R11: a different format mid-frame must not alter the output
      if (fmt_flip) fmt_sel = 2'(fmt ^ 1);
    end
    while (q.size() != 0) @(negedge clk);
    begin
      int seen = 0;
      repeat (40) begin
        @(negedge clk);
        if (pix_valid) seen++;
      end
      check(seen == 0, "R2", "quiet after frame", seen, 0);
    end
    check(rd_idx == NRD, "R12", "reads per frame", rd_idx, NRD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    redraw_req = 1'b0;
    fmt_sel = 2'd3;
    for (int i = 0; i < ROWS * RB; i++) fb[i] = {4'(2 * i), 4'(2 * i + 1)};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) begin
      @(negedge clk);
      check(!pix_valid && !mem_rd, "R1", "idle after reset",
            {pix_valid, mem_rd}, 0);
    end
    run_frame(3, 0, 0);
    rand_ready = 1;
    run_frame(2, 0, 0);
    run_frame(0, 0, 1);
    for (int i = 0; i < ROWS * RB; i++) fb[i] = 8'hF0 ^ 8'(i * 29);
    run_frame(1, 1, 0);
    rand_ready = 0;
    run_frame(0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule